// File: doc/BRIEF.md
# Accumulator Fetch-Execute-Interrupt Sequencer

This block is the control unit and register set of a small accumulator machine. It runs every instruction as a chain of single-clock register transfers through a memory address register and a memory buffer register. It reads and writes a single-word synchronous memory, and each transfer takes one state of its cycle machine. After the execute phase of every instruction it spends one dedicated cycle looking at an interrupt request line. If the request is accepted, the return address and the accumulator are saved in internal shadow registers, and control moves to a fixed handler address.

Instruction words are 16 bits wide. The upper four bits carry the opcode and the lower twelve carry a memory address. The machine loads, stores, adds, jumps, returns from an interrupt and halts. Requests are masked from the moment a handler is entered until the return instruction runs, so handlers do not nest. After a halt, only a reset starts the machine again.

Top module: `acc_seq_top`

## Requirements
- R1: While reset is asserted and right after it is released, the program counter and accumulator are zero, the sequencer is not halted, it is not in an interrupt handler, and neither memory strobe is active.
- R2: A fetch puts the program counter on `mem_addr` with `mem_rd` high for one clock. It takes the read data the next clock as the instruction, then advances the program counter by one. The first fetch after reset reads address 0.
- R3: The instruction encoding is opcode in bits 15:12 and address in bits 11:0. The opcodes are 0 load, 1 store, 2 add, 3 jump, 4 return-from-interrupt and F halt. Every other opcode executes as a no-op that leaves the accumulator and memory untouched.
- R4: A load sets the accumulator to the memory word at the instruction's address.
- R5: A store writes the accumulator to the instruction's address with exactly one `mem_wr` cycle per store.
- R6: An add sets the accumulator to the accumulator plus the memory word, modulo 2^16.
- R7: A jump sets the program counter to the instruction's address, so the words that follow it are skipped.
- R8: The interrupt check comes after each execute. If `irq` is high and interrupts are unmasked, the return address and accumulator are saved, the program counter becomes 0x010, and `in_isr` goes high.
- R9: While `in_isr` is high, `irq` is ignored, so the handler is entered only once.
- R10: Return-from-interrupt restores the saved program counter and accumulator and clears the mask. A request that is still high is then taken at the very next interrupt check.
- R11: A halt stops the sequencer for good until reset. While halted there are no memory accesses, the program counter does not change, and `irq` is ignored.
- R12: `mem_rd` and `mem_wr` are never active in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq | input | 1 | Level interrupt request |
| mem_addr | output | 12 | Memory address (the address register) |
| mem_rd | output | 1 | Read strobe; data is expected on `mem_rdata` one clock later |
| mem_wr | output | 1 | Write strobe for `mem_wdata` at `mem_addr` |
| mem_wdata | output | 16 | Write data (the buffer register) |
| mem_rdata | input | 16 | Read data from the synchronous memory |
| pc_o | output | 12 | Program counter |
| acc_o | output | 16 | Accumulator |
| halted_o | output | 1 | High once a halt instruction has executed |
| in_isr | output | 1 | High from handler entry until return-from-interrupt |

## Verification
The bench holds the request line high across a whole handler. A design that failed to mask would enter the handler again and again, which shows up in a handler-entry counter and in a count kept in memory. It also keeps the request high through the return so that re-entry must happen at once. A design that lost the saved accumulator or return address would end the main program with a wrong sum or a wrong result word. Sums that overflow 16 bits, a skipped word after a jump, an undefined opcode, and requests raised after a halt each expose truncation, a wrong program counter, a stray accumulator change, or wake-up from the halt state. Random straight-line programs are compared with an instruction-level model to cover the ordering of the register transfers.

// File: rtl/acc_seq_pkg.sv
package acc_seq_pkg;
    parameter int unsigned DATA_W = 16;
    parameter int unsigned OP_W   = 4;
    localparam int unsigned ADDR_W = DATA_W - OP_W;

    localparam logic [OP_W-1:0] OPC_LOAD  = 4'h0;
    localparam logic [OP_W-1:0] OPC_STORE = 4'h1;
    localparam logic [OP_W-1:0] OPC_ADD   = 4'h2;
    localparam logic [OP_W-1:0] OPC_JUMP  = 4'h3;
    localparam logic [OP_W-1:0] OPC_RETI  = 4'h4;
    localparam logic [OP_W-1:0] OPC_HALT  = 4'hF;

    typedef enum logic [3:0] {
        ST_F_MAR, ST_F_RD, ST_F_MBR, ST_F_IR, ST_EXEC,
        ST_X_RD, ST_X_MBR, ST_X_ACC, ST_S_MBR, ST_S_WR,
        ST_INT_CHK, ST_HALT
    } state_e;

    typedef enum logic [2:0] {
        OP_LOAD, OP_STORE, OP_ADD, OP_JUMP, OP_RETI, OP_HALT, OP_NOP
    } op_e;

    typedef struct packed {
        state_e              st;
        logic [ADDR_W-1:0]   pc;
        logic [ADDR_W-1:0]   mar;
        logic [ADDR_W-1:0]   shadow_pc;
        logic [DATA_W-1:0]   mbr;
        logic [DATA_W-1:0]   ir;
        logic [DATA_W-1:0]   acc;
        logic [DATA_W-1:0]   shadow_acc;
        logic                masked;
    } regs_t;
endpackage

// File: rtl/acc_seq_decode.sv
module acc_seq_decode
    import acc_seq_pkg::*;
(
    input  logic [OP_W-1:0] opcode,
    output op_e             op
);
    always_comb begin
        case (opcode)
            OPC_LOAD:  op = OP_LOAD;
            OPC_STORE: op = OP_STORE;
            OPC_ADD:   op = OP_ADD;
            OPC_JUMP:  op = OP_JUMP;
            OPC_RETI:  op = OP_RETI;
            OPC_HALT:  op = OP_HALT;
            default:   op = OP_NOP;
        endcase
    end
endmodule

// File: rtl/acc_seq_alu.sv
module acc_seq_alu
    import acc_seq_pkg::*;
(
    input  op_e               op,
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] operand,
    output logic [DATA_W-1:0] result
);
    // Add wraps at the word width; every other operation passes the operand.
    always_comb begin
        if (op == OP_ADD) result = acc + operand;
        else              result = operand;
    end
endmodule

// File: rtl/acc_seq_top.sv
module acc_seq_top
    import acc_seq_pkg::*;
#(
    parameter logic [ADDR_W-1:0] VEC_ADDR = 12'h010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] pc_o,
    output logic [DATA_W-1:0] acc_o,
    output logic              halted_o,
    output logic              in_isr
);
    regs_t r_q, r_d;
    op_e   op;
    logic [DATA_W-1:0] alu_y;
    logic [ADDR_W-1:0] ir_addr;
    logic              rd_d, wr_d;

    assign ir_addr = r_q.ir[ADDR_W-1:0];

    acc_seq_decode u_dec (
        .opcode (r_q.ir[DATA_W-1 -: OP_W]),
        .op     (op)
    );

    acc_seq_alu u_alu (
        .op      (op),
        .acc     (r_q.acc),
        .operand (r_q.mbr),
        .result  (alu_y)
    );

    always_comb begin
        r_d  = r_q;
        rd_d = 1'b0;
        wr_d = 1'b0;
        case (r_q.st)
            ST_F_MAR: begin
                r_d.mar = r_q.pc;
                r_d.st  = ST_F_RD;
            end
            ST_F_RD: begin
                rd_d   = 1'b1;
                r_d.st = ST_F_MBR;
            end
            ST_F_MBR: begin
                r_d.mbr = mem_rdata;
                r_d.st  = ST_F_IR;
            end
            ST_F_IR: begin
                r_d.ir = r_q.mbr;
                r_d.pc = r_q.pc + 1'b1;
                r_d.st = ST_EXEC;
            end
            ST_EXEC: begin
                case (op)
                    OP_LOAD, OP_ADD: begin
                        r_d.mar = ir_addr;
                        r_d.st  = ST_X_RD;
                    end
                    OP_STORE: begin
                        r_d.mar = ir_addr;
                        r_d.st  = ST_S_MBR;
                    end
                    OP_JUMP: begin
                        r_d.pc = ir_addr;
                        r_d.st = ST_INT_CHK;
                    end
                    OP_RETI: begin
                        r_d.pc     = r_q.shadow_pc;
                        r_d.acc    = r_q.shadow_acc;
                        r_d.masked = 1'b0;
                        r_d.st     = ST_INT_CHK;
                    end
                    OP_HALT: r_d.st = ST_HALT;
                    default: r_d.st = ST_INT_CHK;
                endcase
            end
            ST_X_RD: begin
                rd_d   = 1'b1;
                r_d.st = ST_X_MBR;
            end
            ST_X_MBR: begin
                r_d.mbr = mem_rdata;
                r_d.st  = ST_X_ACC;
            end
            ST_X_ACC: begin
                r_d.acc = alu_y;
                r_d.st  = ST_INT_CHK;
            end
            ST_S_MBR: begin
                r_d.mbr = r_q.acc;
                r_d.st  = ST_S_WR;
            end
            ST_S_WR: begin
                wr_d   = 1'b1;
                r_d.st = ST_INT_CHK;
            end
            ST_INT_CHK: begin
                if (irq && !r_q.masked) begin
                    r_d.shadow_pc  = r_q.pc;
                    r_d.shadow_acc = r_q.acc;
                    r_d.pc         = VEC_ADDR;
                    r_d.masked     = 1'b1;
                end
                r_d.st = ST_F_MAR;
            end
            ST_HALT: r_d.st = ST_HALT;
            default: r_d.st = ST_F_MAR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_F_MAR, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_addr  = r_q.mar;
    assign mem_rd    = rd_d;
    assign mem_wr    = wr_d;
    assign mem_wdata = r_q.mbr;
    assign pc_o      = r_q.pc;
    assign acc_o     = r_q.acc;
    assign halted_o  = (r_q.st == ST_HALT);
    assign in_isr    = r_q.masked;
endmodule

// File: rtl/acc_seq_chk.sv
module acc_seq_chk
    import acc_seq_pkg::*;
#(
    parameter logic [ADDR_W-1:0] VEC_ADDR = 12'h010
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irq,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic [ADDR_W-1:0] pc_o,
    input logic              halted_o,
    input logic              in_isr
);
    a_r12_rd_wr_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    a_r11_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        halted_o |=> halted_o);

    a_r11_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        halted_o |-> (!mem_rd && !mem_wr));

    a_r11_halt_pc_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (halted_o && $past(halted_o)) |-> $stable(pc_o));

    a_r8_entry_vectors: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_isr) |-> (pc_o == VEC_ADDR));

    a_r8_entry_needs_irq: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_isr) |-> $past(irq));
endmodule

bind acc_seq_top acc_seq_chk #(.VEC_ADDR(VEC_ADDR)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq      (irq),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .pc_o     (pc_o),
    .halted_o (halted_o),
    .in_isr   (in_isr)
);

// File: tb/acc_seq_top_tb.sv
module acc_seq_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq = 1'b0;
    logic [11:0] mem_addr;
    logic        mem_rd, mem_wr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = 16'h0;
    logic [11:0] pc_o;
    logic [15:0] acc_o;
    logic        halted_o, in_isr;

    int n_tests = 0;
    int n_fail  = 0;
    int wr_count = 0;
    bit done = 0;

    logic [15:0] mem     [0:511];
    logic [15:0] ref_mem [0:511];

    always #4 clk = ~clk;

    acc_seq_top u_dut (
        .clk(clk), .rst_n(rst_n), .irq(irq),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .pc_o(pc_o), .acc_o(acc_o), .halted_o(halted_o), .in_isr(in_isr)
    );

    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem[mem_addr[8:0]];
        if (mem_wr) begin
            mem[mem_addr[8:0]] <= mem_wdata;
            wr_count <= wr_count + 1;
        end
    end

    function automatic logic [15:0] ins(input logic [3:0] op, input logic [11:0] a);
        return {op, a};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic summary;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    task automatic clear_mem;
        for (int i = 0; i < 512; i++) mem[i] = 16'h0;
    endtask

    task automatic start;
        rst_n = 1'b0;
        irq   = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        wr_count = 0;
    endtask

    task automatic run_to_halt(output bit ok);
        ok = 0;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (halted_o) begin ok = 1; break; end
        end
    endtask

    // Instruction-level model of a program without interrupts.
    function automatic logic [15:0] model_run();
        logic [15:0] acc = 16'h0;
        logic [11:0] pc = 12'h0;
        for (int s = 0; s < 500; s++) begin
            logic [15:0] w;
            w = ref_mem[pc[8:0]];
            pc = pc + 1'b1;
            case (w[15:12])
                4'h0: acc = ref_mem[w[8:0]];
                4'h1: ref_mem[w[8:0]] = acc;
                4'h2: acc = acc + ref_mem[w[8:0]];
                4'h3: pc = w[11:0];
                4'hF: break;
                default: ;
            endcase
        end
        return acc;
    endfunction

    task automatic snapshot;
        for (int i = 0; i < 512; i++) ref_mem[i] = mem[i];
    endtask

    task automatic load_irq_prog;
        clear_mem;
        mem[0] = ins(4'h0, 12'h100);
        for (int i = 1; i <= 8; i++) mem[i] = ins(4'h2, 12'h101);
        mem[9]  = ins(4'h1, 12'h102);
        mem[10] = ins(4'hF, 12'h000);
        mem[16] = ins(4'h0, 12'h105);
        mem[17] = ins(4'h2, 12'h106);
        mem[18] = ins(4'h1, 12'h105);
        mem[19] = ins(4'h4, 12'h000);
        mem[9'h100] = 16'd5;
        mem[9'h101] = 16'd3;
        mem[9'h106] = 16'd1;
    endtask

    // Raise irq, keep it high through 'keep' handler exits, count entries.
    task automatic irq_run(input int keep, output int entries);
        bit prev = 0;
        int exits = 0;
        bit ok;
        entries = 0;
        repeat (20) @(negedge clk);
        irq = 1'b1;
        for (int i = 0; i < 2000 && exits < keep; i++) begin
            @(negedge clk);
            if (in_isr && !prev) begin
                entries++;
                if (entries == 1)
                    check(pc_o == 12'h010, "R8 vector on entry", pc_o, 12'h010);
            end
            if (!in_isr && prev) exits++;
            prev = in_isr;
        end
        irq = 1'b0;
        for (int i = 0; i < 2000 && !halted_o; i++) begin
            @(negedge clk);
            if (in_isr && !prev) entries++;
            prev = in_isr;
        end
        run_to_halt(ok);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            summary;
        end
    end

    initial begin
        bit ok;
        int ent;
        logic [15:0] exp_acc;
        void'($urandom(32'h5EED_0042));

        // R1 / R2: reset state and first fetch
        clear_mem;
        mem[0] = ins(4'hF, 12'h0);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(!mem_rd && !mem_wr, "R1 strobes in reset", {mem_rd, mem_wr}, 0);
        rst_n = 1'b1;
        check(pc_o == 0 && acc_o == 0, "R1 pc/acc after reset", {pc_o, acc_o}, 0);
        check(!halted_o && !in_isr, "R1 flags after reset", {halted_o, in_isr}, 0);
        @(negedge clk);
        check(mem_rd && mem_addr == 0, "R2 first fetch read", {mem_rd, mem_addr}, {1'b1, 12'h0});
        run_to_halt(ok);
        check(ok && pc_o == 12'h001, "R2 pc advanced after fetch", pc_o, 12'h001);

        // R6: add wraps modulo 2^16
        clear_mem;
        mem[0] = ins(4'h0, 12'h100);
        mem[1] = ins(4'h2, 12'h101);
        mem[2] = ins(4'hF, 12'h0);
        mem[9'h100] = 16'hFFF0;
        mem[9'h101] = 16'h0025;
        start;
        run_to_halt(ok);
        check(ok && acc_o == 16'h0015, "R6 add wrap", acc_o, 16'h0015);

        // R7 / R5 / R4: jump skips a word, single write pulse per store
        clear_mem;
        mem[0] = ins(4'h0, 12'h100);
        mem[1] = ins(4'h3, 12'h003);
        mem[2] = ins(4'h2, 12'h101);
        mem[3] = ins(4'h1, 12'h102);
        mem[4] = ins(4'hF, 12'h0);
        mem[9'h100] = 16'h1234;
        mem[9'h101] = 16'h1111;
        start;
        run_to_halt(ok);
        check(acc_o == 16'h1234, "R7 skipped add / R4 load", acc_o, 16'h1234);
        check(mem[9'h102] == 16'h1234, "R5 stored word", mem[9'h102], 16'h1234);
        check(wr_count == 1, "R5 one write strobe", wr_count, 1);

        // R3: undefined opcode is a no-op
        clear_mem;
        mem[0] = ins(4'h0, 12'h100);
        mem[1] = ins(4'h7, 12'h101);
        mem[2] = ins(4'hC, 12'h101);
        mem[3] = ins(4'hF, 12'h0);
        mem[9'h100] = 16'hBEEF;
        mem[9'h101] = 16'h0;
        start;
        run_to_halt(ok);
        check(acc_o == 16'hBEEF, "R3 undefined opcode acc", acc_o, 16'hBEEF);
        check(wr_count == 0 && mem[9'h101] == 0, "R3 undefined opcode memory", wr_count, 0);

        // R11: halted machine ignores irq and stays still
        irq = 1'b1;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (mem_rd || mem_wr || in_isr || pc_o != 12'h004) begin
                check(0, "R11 activity while halted", {mem_rd, mem_wr, in_isr, pc_o}, 12'h004);
                break;
            end
        end
        check(halted_o && pc_o == 12'h004 && !in_isr, "R11 halt holds", pc_o, 12'h004);
        irq = 1'b0;

        // R8 / R9 / R10: single interrupt with irq held through the handler
        load_irq_prog;
        start;
        irq_run(1, ent);
        check(ent == 1, "R9 masked while in handler", ent, 1);
        check(mem[9'h105] == 16'd1, "R8 handler ran once", mem[9'h105], 1);
        check(acc_o == 16'd29, "R10 acc restored", acc_o, 16'd29);
        check(mem[9'h102] == 16'd29, "R10 resumed main", mem[9'h102], 16'd29);

        // R10: irq still high after return re-enters at once
        load_irq_prog;
        start;
        irq_run(2, ent);
        check(ent == 2, "R10 re-entry count", ent, 2);
        check(mem[9'h105] == 16'd2, "R10 handler ran twice", mem[9'h105], 2);
        check(acc_o == 16'd29 && halted_o, "R10 acc after two entries", acc_o, 16'd29);

        // R4 / R5 / R6 / R7: random programs against the model
        for (int t = 0; t < 25; t++) begin
            bit mem_ok;
            clear_mem;
            for (int i = 0; i < 12; i++) begin
                int k;
                logic [3:0] opc;
                logic [11:0] a;
                k = $urandom_range(0, 9);
                a = 12'h100 + 12'($urandom_range(0, 15));
                if (k < 3)       opc = 4'h0;
                else if (k < 5)  opc = 4'h1;
                else if (k < 8)  opc = 4'h2;
                else if (k == 8) begin
                    opc = 4'h3;
                    a = 12'(i + 1 + $urandom_range(0, 12 - i - 1));
                end else         opc = 4'h9;
                mem[i] = ins(opc, a);
            end
            mem[12] = ins(4'hF, 12'h0);
            for (int i = 0; i < 16; i++) mem[9'h100 + i] = 16'($urandom);
            snapshot;
            exp_acc = model_run();
            start;
            run_to_halt(ok);
            check(ok && acc_o == exp_acc, "R4/R6 random acc", acc_o, exp_acc);
            mem_ok = 1;
            for (int i = 0; i < 16; i++)
                if (mem[9'h100 + i] != ref_mem[9'h100 + i]) mem_ok = 0;
            check(mem_ok, "R5/R7 random memory", mem_ok, 1);
        end

        done = 1;
        summary;
    end
endmodule